// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Mode-Dependent Saturation

This block multiplies two signed operands and adds the product into a 64-bit accumulator that is presented as two 32-bit halves, an upper word and a lower word. Two operating modes are offered. The long mode forms the full product of two signed 32-bit operands. The word mode uses only the lower 16 bits of each operand, treats them as signed values and ignores the upper bits. A pulse on `start` launches one operation. The accumulator changes two rising edges after the pulse, and `done` is raised for one cycle after that.

When saturation is requested with the operation, the limiting rule depends on the mode. In long mode the upper word is held inside a 48-bit signed range by a fixed bit rule. When the result is negative, the top 16 bits of the upper word are forced to ones. When the result is non-negative, only the low 15 bits of the upper word are kept. In word mode the accumulator is clamped to the signed 32-bit limits, and a clamp is marked by writing the value 1 into the upper word. Software-facing controls let the accumulator be loaded with an arbitrary value or cleared. A synchronous reset also clears it.

Top module: `signed_mac_sat`

## Requirements
- R1: Synchronous reset, and `acc_clear` asserted at a rising edge, set both accumulator words to zero. After reset `done` is low.
- R2: A `start` pulse sampled at edge E0 updates the accumulator at edge E1. `done` is high for exactly one cycle, from edge E2 to edge E3.
- R3: With `long_mode`=1 the accumulator grows by the signed 64-bit product of `op_a` and `op_b`, both read as signed 32-bit values.
- R4: With `long_mode`=0 the accumulator grows by the product of `op_a[15:0]` and `op_b[15:0]`, both read as signed values. Bits [31:16] of the operands have no effect.
- R5: With long mode and `sat_en`=1, a sum that is negative as a 64-bit value gets bits [31:16] of `acc_hi` forced to 0xFFFF. The other bits are kept.
- R6: With long mode and `sat_en`=1, a non-negative sum leaves `acc_hi` equal to its bits [14:0] with bits [31:15] cleared. `acc_lo` is kept.
- R7: With word mode and `sat_en`=1, a sum below -2^31 gives `acc_lo`=0x80000000 and `acc_hi`=1.
- R8: With word mode and `sat_en`=1, a sum above 2^31-1 gives `acc_lo`=0x7FFFFFFF and `acc_hi`=1.
- R9: With word mode and `sat_en`=1, a sum that lies exactly at -2^31 or exactly at 2^31-1 is stored unchanged.
- R10: With `sat_en`=0 the sum wraps modulo 2^64 with no limiting, in either mode.
- R11: `acc_load` writes `load_hi` and `load_lo` into the accumulator at the next edge. `acc_clear` has priority over `acc_load`. Both have priority over a pending multiply-accumulate write in the same cycle.
- R12: The mode, `sat_en` and the operands are taken only in the `start` cycle. Changing them in the following cycle does not alter the result.
- R13: `start` may be asserted on consecutive cycles. Each operation is accumulated in order, and `done` is raised once per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one multiply-accumulate |
| long_mode | input | 1 | 1: 32x32 signed product, 0: 16x16 signed product |
| sat_en | input | 1 | Apply the mode's saturation rule to this operation |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_load | input | 1 | Write load_hi/load_lo into the accumulator |
| load_hi | input | 32 | Upper word value to load |
| load_lo | input | 32 | Lower word value to load |
| acc_clear | input | 1 | Zero the accumulator |
| acc_hi | output | 32 | Accumulator upper word |
| acc_lo | output | 32 | Accumulator lower word |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with its default widths: 32-bit operands, a 16-bit word-mode field and a two-stage completion lag. With these widths the clamp thresholds at plus and minus 2^31 are reachable. The bench loads the accumulator a few counts away from each threshold, so that a single small product lands just inside, exactly on, or just beyond a limit. Because the 48-bit long-mode boundary sits inside the upper word, a loaded upper word with mixed bit patterns shows which bits the masking keeps.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Multiplier operand width selection
    typedef enum logic {
        MODE_WORD = 1'b0,
        MODE_LONG = 1'b1
    } mac_mode_e;

    // Control carried alongside a product through the pipeline
    typedef struct packed {
        logic      valid;
        mac_mode_e mode;
        logic      sat;
    } mac_ctl_t;

    localparam int unsigned MAC_OP_W   = 32;
    localparam int unsigned MAC_WORD_W = 16;

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int OP_W   = MAC_OP_W,
    parameter int WORD_W = MAC_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mac_mode_e         mode,
    input  logic              sat,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output mac_ctl_t          ctl_q,
    output logic [2*OP_W-1:0] prod_q
);
    localparam int ACC_W = 2 * OP_W;
    localparam int EXT_W = OP_W - WORD_W;

    logic [OP_W-1:0]         a_sel, b_sel;
    logic signed [ACC_W-1:0] a_wide, b_wide, prod_c;

    // Operand selection: full width or sign-extended narrow field
    always_comb begin
        if (mode == MODE_LONG) begin
            a_sel = op_a;
            b_sel = op_b;
        end else begin
            a_sel = {{EXT_W{op_a[WORD_W-1]}}, op_a[WORD_W-1:0]};
            b_sel = {{EXT_W{op_b[WORD_W-1]}}, op_b[WORD_W-1:0]};
        end
        a_wide = {{OP_W{a_sel[OP_W-1]}}, a_sel};
        b_wide = {{OP_W{b_sel[OP_W-1]}}, b_sel};
        prod_c = a_wide * b_wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{valid: 1'b0, mode: MODE_WORD, sat: 1'b0};
            prod_q <= '0;
        end else begin
            ctl_q.valid <= start;
            if (start) begin
                ctl_q.mode <= mode;
                ctl_q.sat  <= sat;
                prod_q     <= prod_c;
            end
        end
    end

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_pkg::*;
#(
    parameter int OP_W = MAC_OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mac_ctl_t          ctl,
    input  logic [2*OP_W-1:0] prod,
    input  logic              acc_clear,
    input  logic              acc_load,
    input  logic [OP_W-1:0]   load_hi,
    input  logic [OP_W-1:0]   load_lo,
    output logic [OP_W-1:0]   acc_hi,
    output logic [OP_W-1:0]   acc_lo
);
    localparam int ACC_W  = 2 * OP_W;
    localparam int TOP_W  = OP_W / 2;
    localparam int KEEP_W = OP_W - TOP_W - 1;
    localparam logic [ACC_W-1:0] LIM_POS = {{(OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] LIM_NEG = {{(OP_W+1){1'b1}}, {(OP_W-1){1'b0}}};
    localparam logic [OP_W-1:0]  FLAG_HI = OP_W'(1);

    logic [ACC_W-1:0] sum_c;
    logic [OP_W-1:0]  sum_hi, sum_lo;
    logic [OP_W-1:0]  nxt_hi, nxt_lo;

    always_comb begin
        sum_c  = {acc_hi, acc_lo} + prod;
        sum_hi = sum_c[ACC_W-1:OP_W];
        sum_lo = sum_c[OP_W-1:0];
        nxt_hi = sum_hi;
        nxt_lo = sum_lo;
        if (ctl.sat) begin
            if (ctl.mode == MODE_LONG) begin
                // Keep the upper word inside a 48-bit signed span
                if (sum_c[ACC_W-1])
                    nxt_hi = {{TOP_W{1'b1}}, sum_hi[OP_W-TOP_W-1:0]};
                else
                    nxt_hi = {{(TOP_W+1){1'b0}}, sum_hi[KEEP_W-1:0]};
            end else begin
                // Clamp to the signed lower-word range, mark in upper word
                if ($signed(sum_c) < $signed(LIM_NEG)) begin
                    nxt_hi = FLAG_HI;
                    nxt_lo = {1'b1, {(OP_W-1){1'b0}}};
                end else if ($signed(sum_c) > $signed(LIM_POS)) begin
                    nxt_hi = FLAG_HI;
                    nxt_lo = {1'b0, {(OP_W-1){1'b1}}};
                end
            end
        end
    end

    // Priority: reset/clear, then load, then accumulate
    always_ff @(posedge clk) begin
        if (rst || acc_clear) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (acc_load) begin
            acc_hi <= load_hi;
            acc_lo <= load_lo;
        end else if (ctl.valid) begin
            acc_hi <= nxt_hi;
            acc_lo <= nxt_lo;
        end
    end

endmodule

// File: rtl/mac_done_delay.sv
module mac_done_delay #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pulse,
    output logic out_pulse
);
    logic [LAG-1:0] sh_q;

    generate
        if (LAG == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= in_pulse;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[LAG-2:0], in_pulse};
            end
        end
    endgenerate

    assign out_pulse = sh_q[LAG-1];

endmodule

// File: rtl/signed_mac_sat.sv
module signed_mac_sat
    import mac_pkg::*;
#(
    parameter int OP_W     = MAC_OP_W,
    parameter int WORD_W   = MAC_WORD_W,
    parameter int DONE_LAG = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            long_mode,
    input  logic            sat_en,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            acc_load,
    input  logic [OP_W-1:0] load_hi,
    input  logic [OP_W-1:0] load_lo,
    input  logic            acc_clear,
    output logic [OP_W-1:0] acc_hi,
    output logic [OP_W-1:0] acc_lo,
    output logic            done
);
    localparam int ACC_W = 2 * OP_W;

    mac_mode_e        mode_in;
    mac_ctl_t         ctl_q;
    logic [ACC_W-1:0] prod_q;
    logic             wr_valid, wr_long, wr_sat;

    assign mode_in  = long_mode ? MODE_LONG : MODE_WORD;
    assign wr_valid = ctl_q.valid;
    assign wr_long  = (ctl_q.mode == MODE_LONG);
    assign wr_sat   = ctl_q.sat;

    mac_mul_stage #(.OP_W(OP_W), .WORD_W(WORD_W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .mode   (mode_in),
        .sat    (sat_en),
        .op_a   (op_a),
        .op_b   (op_b),
        .ctl_q  (ctl_q),
        .prod_q (prod_q)
    );

    mac_acc_stage #(.OP_W(OP_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_q),
        .prod      (prod_q),
        .acc_clear (acc_clear),
        .acc_load  (acc_load),
        .load_hi   (load_hi),
        .load_lo   (load_lo),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo)
    );

    mac_done_delay #(.LAG(DONE_LAG)) u_done (
        .clk       (clk),
        .rst       (rst),
        .in_pulse  (ctl_q.valid),
        .out_pulse (done)
    );

endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
    parameter int OP_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            acc_clear,
    input logic            acc_load,
    input logic [OP_W-1:0] load_hi,
    input logic [OP_W-1:0] load_lo,
    input logic [OP_W-1:0] acc_hi,
    input logic [OP_W-1:0] acc_lo,
    input logic            done,
    input logic            wr_valid,
    input logic            wr_long,
    input logic            wr_sat
);
    localparam int TOP_W = OP_W / 2;

    logic s1, s2, s3;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
        end else begin
            s1 <= start; s2 <= s1; s3 <= s2;
        end
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        acc_clear |=> (acc_hi == '0 && acc_lo == '0));

    // R11
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_load && !acc_clear) |=>
            (acc_hi == $past(load_hi) && acc_lo == $past(load_lo)));

    // R2
    done_lag_chk: assert property (@(posedge clk) disable iff (rst)
        done == s3);

    // R5 R6
    long_span_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_long && wr_sat && !acc_clear && !acc_load) |=>
            (acc_hi[OP_W-1:OP_W-TOP_W] == {TOP_W{1'b1}} ||
             acc_hi[OP_W-1:OP_W-TOP_W-1] == '0));

    // R7 R8
    word_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_long && wr_sat && !acc_clear && !acc_load) |=>
            ((acc_hi == OP_W'(1)) ?
                (acc_lo == {1'b1, {(OP_W-1){1'b0}}} ||
                 acc_lo == {1'b0, {(OP_W-1){1'b1}}}) :
                (acc_hi == {OP_W{acc_lo[OP_W-1]}})));

endmodule

bind signed_mac_sat mac_sat_chk #(.OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .acc_clear (acc_clear),
    .acc_load  (acc_load),
    .load_hi   (load_hi),
    .load_lo   (load_lo),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_long   (wr_long),
    .wr_sat    (wr_sat)
);

// File: tb/test_signed_mac_sat.sv
module test_signed_mac_sat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, long_mode = 1'b0, sat_en = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        acc_load = 1'b0, acc_clear = 1'b0;
    logic [31:0] load_hi = '0, load_lo = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int checks = 0;
    int errors = 0;
    longint acc_m = 0;

    always #4 clk = ~clk;

    signed_mac_sat i_signed_mac_sat (
        .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .acc_load(acc_load),
        .load_hi(load_hi), .load_lo(load_lo), .acc_clear(acc_clear),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    function automatic longint model_step(longint acc, bit lng, bit sat,
                                          logic [31:0] a, logic [31:0] b);
        longint p, s;
        if (lng) p = longint'($signed(a)) * longint'($signed(b));
        else     p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        s = acc + p;
        if (sat && lng) begin
            if (s < 0) s[63:48] = 16'hFFFF;
            else       s[63:47] = '0;
        end else if (sat) begin
            if (s < -64'sd2147483648)     s = {32'd1, 32'h80000000};
            else if (s > 64'sd2147483647) s = {32'd1, 32'h7FFFFFFF};
        end
        return s;
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic load_acc(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        acc_load = 1'b1; load_hi = hi; load_lo = lo;
        @(negedge clk);
        acc_load = 1'b0;
        acc_m = {hi, lo};
        check64("R11 load", {acc_hi, acc_lo}, acc_m);
    endtask

    // One operation; inputs are scrambled right after sampling (R12)
    task automatic run_mac(input bit lng, input bit sat, input logic [31:0] a,
                           input logic [31:0] b, input string tag);
        @(negedge clk);
        start = 1'b1; long_mode = lng; sat_en = sat; op_a = a; op_b = b;
        @(negedge clk);
        start = 1'b0; long_mode = ~lng; sat_en = ~sat; op_a = ~a; op_b = ~b;
        check1({tag, " R2 done early"}, done, 1'b0);
        @(negedge clk);
        acc_m = model_step(acc_m, lng, sat, a, b);
        check64(tag, {acc_hi, acc_lo}, acc_m);
        check1({tag, " R2 done before E2"}, done, 1'b0);
        @(negedge clk);
        check1({tag, " R2 done at E2"}, done, 1'b1);
        @(negedge clk);
        check1({tag, " R2 done one cycle"}, done, 1'b0);
    endtask

    task automatic t_reset;
        check64("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
        check1("R1 reset done", done, 1'b0);
    endtask

    task automatic t_long;
        load_acc(32'h0, 32'h0);
        run_mac(1, 0, 32'hFFFF_FFFD, 32'd7, "R3 long negative product");
        run_mac(1, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 long large product");
        check64("R3 long large value", {acc_hi, acc_lo}, 64'h3FFF_FFFF_0000_0001 - 64'd21);
    endtask

    task automatic t_word;
        load_acc(32'h0, 32'd100);
        run_mac(0, 0, 32'hABCD_0005, 32'h1234_FFFE, "R4 word ignores upper bits");
        check64("R4 word value", {acc_hi, acc_lo}, 64'd90);
    endtask

    task automatic t_long_sat;
        load_acc(32'h0012_3456, 32'h0000_0010);
        run_mac(1, 1, 32'd1, 32'd1, "R6 long sat non-negative");
        check64("R6 long sat mask", {acc_hi, acc_lo}, {32'h0000_3456, 32'h0000_0011});
        load_acc(32'h8000_9234, 32'h5);
        run_mac(1, 1, 32'd0, 32'd0, "R5 long sat negative");
        check64("R5 long sat fill", {acc_hi, acc_lo}, {32'hFFFF_9234, 32'h5});
    endtask

    task automatic t_word_sat;
        load_acc(32'h0, 32'h7FFF_FFF0);
        run_mac(0, 1, 32'd4, 32'd4, "R8 word clamp high");
        check64("R8 clamp value", {acc_hi, acc_lo}, {32'd1, 32'h7FFF_FFFF});
        load_acc(32'hFFFF_FFFF, 32'h8000_0005);
        run_mac(0, 1, 32'hFFFF_FFFD, 32'd2, "R7 word clamp low");
        check64("R7 clamp value", {acc_hi, acc_lo}, {32'd1, 32'h8000_0000});
        load_acc(32'h0, 32'h7FFF_FFF0);
        run_mac(0, 1, 32'd3, 32'd5, "R9 word exactly max");
        check64("R9 max kept", {acc_hi, acc_lo}, {32'h0, 32'h7FFF_FFFF});
        load_acc(32'hFFFF_FFFF, 32'h8000_0006);
        run_mac(0, 1, 32'hFFFF_FFFA, 32'd1, "R9 word exactly min");
        check64("R9 min kept", {acc_hi, acc_lo}, {32'hFFFF_FFFF, 32'h8000_0000});
    endtask

    task automatic t_no_sat;
        load_acc(32'h0, 32'h7FFF_FFF0);
        run_mac(0, 0, 32'd4, 32'd4, "R10 word no clamp");
        check64("R10 word wrap value", {acc_hi, acc_lo}, {32'h0, 32'h8000_0000});
        load_acc(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run_mac(1, 0, 32'd1, 32'd1, "R10 long 64-bit wrap");
        check64("R10 wrap value", {acc_hi, acc_lo}, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_priority;
        load_acc(32'h0, 32'd100);
        @(negedge clk);
        start = 1'b1; long_mode = 1'b1; sat_en = 1'b0; op_a = 32'd2; op_b = 32'd3;
        @(negedge clk);
        start = 1'b0; acc_load = 1'b1; load_hi = 32'h0; load_lo = 32'd55;
        @(negedge clk);
        acc_load = 1'b0;
        acc_m = 64'd55;
        check64("R11 load beats pending write", {acc_hi, acc_lo}, acc_m);
        @(negedge clk);
        check1("R2 done after overridden op", done, 1'b1);
        acc_clear = 1'b1; acc_load = 1'b1; load_hi = 32'h1234; load_lo = 32'h5678;
        @(negedge clk);
        acc_clear = 1'b0; acc_load = 1'b0;
        acc_m = 0;
        check64("R11 clear beats load", {acc_hi, acc_lo}, 64'd0);
        load_acc(32'hDEAD_BEEF, 32'h1);
        @(negedge clk);
        acc_clear = 1'b1;
        @(negedge clk);
        acc_clear = 1'b0;
        acc_m = 0;
        check64("R1 clear", {acc_hi, acc_lo}, 64'd0);
    endtask

    task automatic t_back_to_back;
        load_acc(32'h0, 32'h0);
        @(negedge clk);
        start = 1'b1; long_mode = 1'b1; sat_en = 1'b0; op_a = 32'd10; op_b = 32'd20;
        @(negedge clk);
        long_mode = 1'b0; op_a = 32'h7777_FFFF; op_b = 32'h0000_0009;
        @(negedge clk);
        start = 1'b0;
        check64("R13 first result", {acc_hi, acc_lo}, 64'd200);
        @(negedge clk);
        check64("R13 second result", {acc_hi, acc_lo}, 64'd191);
        check1("R13 done first", done, 1'b1);
        @(negedge clk);
        check1("R13 done second", done, 1'b1);
        @(negedge clk);
        check1("R13 done ends", done, 1'b0);
        acc_m = 64'd191;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_long();
        t_word();
        t_long_sat();
        t_word_sat();
        t_no_sat();
        t_priority();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule